// File: doc/BRIEF.md
# Interprocessor Message Mailbox

This block lets several processors on one chip pass 32-bit words to each other through a set of one-way message queues. A sender writes a word to a queue's message register, which pushes it. A receiver reads the same register, which pops the oldest word. Per-queue status registers report whether the queue is full and how many words it holds. They sit next to the revision register in a single word-addressed register space, reached through a simple bus: address, write strobe, write data, read strobe and read data. Read data is combinational and belongs to the cycle in which the read strobe is high. The pop takes effect at the end of that cycle.

Each interrupt user has a status register and an enable register. Each queue owns two status bits in every user. One is set when a word enters the queue, and one is set when the queue stops being full. The user's level interrupt line is high whenever a status bit and its enable bit are both set. A parameter picks between two register layouts. In the basic layout the enable register is plain read/write. In the extended layout writing ones to the enable register sets those bits, and a separate clear alias exists.

Each queue is governed by a three-state occupancy machine:
- ST_EMPTY, with transition EMPTY_TO_PARTIAL on an accepted push.
- ST_PARTIAL, with transition PARTIAL_TO_FULL on a push that fills the last slot, and PARTIAL_TO_EMPTY on a pop of the last word.
- ST_FULL, with transition FULL_TO_PARTIAL on a pop.

Pushes into ST_FULL and pops from ST_EMPTY leave the state unchanged. With the default of 4 queues, 3 users and a depth of 4, all register offsets below are byte addresses.

Top module: `mbx_top`

## Requirements
- R1: Offset 0x000 reads the revision. Bits 7:4 hold the major number (default 2) and bits 3:0 the minor number (default 1), so the default value is 0x21. All other bits read zero, and writes to this offset have no effect.
- R2: Queue m's message register is at 0x040+4*m. A write pushes the word and a read pops one. Words leave in the order they entered, and each queue holds up to 4 words.
- R3: The full flag at 0x080+4*m reads 1 when queue m holds 4 words and 0 otherwise. The count at 0x0C0+4*m reads the number of words held. Writes to either register have no effect.
- R4: A write to a full queue is dropped, and the queue's count and contents stay unchanged. A read of an empty queue returns 0 and changes nothing.
- R5: In every user's status register, bit 2*m is set on the cycle a word is accepted into queue m. Bit 2*m+1 is set on the cycle queue m goes from full to not full.
- R6: Writing a 1 to a status bit clears it, and writing 0 leaves it unchanged. If a hardware set and a software clear land on the same cycle, the set wins.
- R7: irq_o[u] is high exactly when user u's status AND enable is nonzero. It follows the register values from the cycle after they change.
- R8: In the basic layout (EXT=0), user u's status register is at 0x100+8*u and its enable register at 0x104+8*u. The enable register is a plain read/write register, so rewriting it with a bit cleared disables that source.
- R9: In the extended layout (EXT=1), user u's status register is at 0x104+0x10*u. Writing ones to 0x108+0x10*u sets enable bits, and writing ones to 0x10C+0x10*u clears them. Both offsets read back the enable value.
- R10: Offsets that map to no register read 0, and writes to them change nothing.
- R11: After reset all queues are empty and all status and enable bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 9 | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DW (32) | Write data |
| bus_re | input | 1 | Read strobe; pops a message register |
| bus_rdata | output | DW (32) | Read data for the addressed register |
| irq_o | output | NU (3) | One level interrupt per user |

## Verification
The hardest event to reach is the not-full status bit. It only appears when a queue is driven to exactly four words and then popped. The bench therefore fills one queue, confirms that a fifth write is dropped, and only then drains the queue, checking the order of the words and the empty-read value. Every user's status is then read back for both bits of that queue. The extended layout is covered by a second instance that shares the address and data lines but has its own strobes.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
    localparam int AW = 9;

    localparam logic [AW-1:0] OFS_REV = 9'h000;
    localparam logic [AW-1:0] OFS_MSG = 9'h040;
    localparam logic [AW-1:0] OFS_FST = 9'h080;
    localparam logic [AW-1:0] OFS_CNT = 9'h0C0;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } q_state_e;

    function automatic logic [AW-1:0] msg_ofs(input int m);
        return AW'(32'h040 + 4 * m);
    endfunction

    function automatic logic [AW-1:0] fst_ofs(input int m);
        return AW'(32'h080 + 4 * m);
    endfunction

    function automatic logic [AW-1:0] cnt_ofs(input int m);
        return AW'(32'h0C0 + 4 * m);
    endfunction

    function automatic logic [AW-1:0] stat_ofs(input int u, input bit ext);
        return ext ? AW'(32'h104 + 16 * u) : AW'(32'h100 + 8 * u);
    endfunction

    function automatic logic [AW-1:0] en_ofs(input int u, input bit ext);
        return ext ? AW'(32'h108 + 16 * u) : AW'(32'h104 + 8 * u);
    endfunction

    function automatic logic [AW-1:0] enclr_ofs(input int u);
        return AW'(32'h10C + 16 * u);
    endfunction
endpackage

// File: rtl/mbx_queue.sv
`timescale 1ns/1ps
module mbx_queue
    import mbx_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic                          pop,
    input  logic [DW-1:0]                 wdata,
    output logic [DW-1:0]                 head,
    output logic                          full,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic                          accepted,
    output logic                          left_full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    q_state_e        st_q, st_d;
    logic [DW-1:0]   mem_q [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   cnt_q;
    logic            take;

    // occupancy machine: next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY: begin
                if (accepted) st_d = (DEPTH == 1) ? ST_FULL : ST_PARTIAL;      // EMPTY_TO_PARTIAL
            end
            ST_PARTIAL: begin
                if (accepted && !take && cnt_q == CW'(DEPTH - 1))
                    st_d = ST_FULL;                                            // PARTIAL_TO_FULL
                else if (take && !accepted && cnt_q == CW'(1))
                    st_d = ST_EMPTY;                                           // PARTIAL_TO_EMPTY
            end
            ST_FULL: begin
                if (take) st_d = (DEPTH == 1) ? ST_EMPTY : ST_PARTIAL;         // FULL_TO_PARTIAL
            end
            default: st_d = ST_EMPTY;
        endcase
    end

    // occupancy machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    // occupancy machine: outputs
    always_comb begin
        full      = (st_q == ST_FULL);
        accepted  = push && (st_q != ST_FULL);
        take      = pop  && (st_q != ST_EMPTY);
        left_full = take && (st_q == ST_FULL);
        head      = (st_q == ST_EMPTY) ? '0 : mem_q[rd_ptr];
        count     = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (accepted) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
            if (take)     rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
            cnt_q <= cnt_q + CW'(accepted) - CW'(take);
        end
    end

    always_ff @(posedge clk) begin
        if (accepted) mem_q[wr_ptr] <= wdata;
    end
endmodule

// File: rtl/mbx_user.sv
`timescale 1ns/1ps
module mbx_user #(
    parameter int SW  = 8,
    parameter bit EXT = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] hw_set,
    input  logic          st_we,
    input  logic          en_we,
    input  logic          enclr_we,
    input  logic [SW-1:0] wdata,
    output logic [SW-1:0] status,
    output logic [SW-1:0] enable,
    output logic          irq
);
    logic [SW-1:0] st_q, en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            en_q <= '0;
        end else begin
            // software clear first, hardware set on top: the set wins
            st_q <= (st_we ? (st_q & ~wdata) : st_q) | hw_set;
            if (enclr_we)   en_q <= en_q & ~wdata;
            else if (en_we) en_q <= EXT ? (en_q | wdata) : wdata;
        end
    end

    assign status = st_q;
    assign enable = en_q;
    assign irq    = |(st_q & en_q);
endmodule

// File: rtl/mbx_top.sv
`timescale 1ns/1ps
module mbx_top
    import mbx_pkg::*;
#(
    parameter int         NQ        = 4,
    parameter int         NU        = 3,
    parameter int         DEPTH     = 4,
    parameter int         DW        = 32,
    parameter bit         EXT       = 1'b0,
    parameter logic [3:0] REV_MAJOR = 4'd2,
    parameter logic [3:0] REV_MINOR = 4'd1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [8:0]    bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_re,
    output logic [DW-1:0] bus_rdata,
    output logic [NU-1:0] irq_o
);
    localparam int SW = 2 * NQ;
    localparam int CW = $clog2(DEPTH + 1);

    logic [NQ-1:0]           push_v, pop_v, q_full, q_accept, q_left;
    logic [NQ-1:0][DW-1:0]   q_head;
    logic [NQ-1:0][CW-1:0]   q_count;
    logic [SW-1:0]           hw_set;
    logic [NU-1:0][SW-1:0]   stat_q, en_q;
    logic [NU-1:0]           st_we_v, en_we_v, enclr_we_v;

    for (genvar m = 0; m < NQ; m++) begin : g_queue
        assign push_v[m] = bus_we && (bus_addr == msg_ofs(m));
        assign pop_v[m]  = bus_re && (bus_addr == msg_ofs(m));

        mbx_queue #(.DW(DW), .DEPTH(DEPTH)) u_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push_v[m]),
            .pop       (pop_v[m]),
            .wdata     (bus_wdata),
            .head      (q_head[m]),
            .full      (q_full[m]),
            .count     (q_count[m]),
            .accepted  (q_accept[m]),
            .left_full (q_left[m])
        );

        assign hw_set[2*m]   = q_accept[m];
        assign hw_set[2*m+1] = q_left[m];
    end

    for (genvar u = 0; u < NU; u++) begin : g_user
        assign st_we_v[u] = bus_we && (bus_addr == stat_ofs(u, EXT));
        assign en_we_v[u] = bus_we && (bus_addr == en_ofs(u, EXT));
        if (EXT) begin : g_clr
            assign enclr_we_v[u] = bus_we && (bus_addr == enclr_ofs(u));
        end else begin : g_noclr
            assign enclr_we_v[u] = 1'b0;
        end

        mbx_user #(.SW(SW), .EXT(EXT)) u_usr (
            .clk      (clk),
            .rst_n    (rst_n),
            .hw_set   (hw_set),
            .st_we    (st_we_v[u]),
            .en_we    (en_we_v[u]),
            .enclr_we (enclr_we_v[u]),
            .wdata    (bus_wdata[SW-1:0]),
            .status   (stat_q[u]),
            .enable   (en_q[u]),
            .irq      (irq_o[u])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_REV) bus_rdata[7:0] = {REV_MAJOR, REV_MINOR};
        for (int m = 0; m < NQ; m++) begin
            if (bus_addr == msg_ofs(m)) bus_rdata = q_head[m];
            if (bus_addr == fst_ofs(m)) bus_rdata = DW'(q_full[m]);
            if (bus_addr == cnt_ofs(m)) bus_rdata = DW'(q_count[m]);
        end
        for (int u = 0; u < NU; u++) begin
            if (bus_addr == stat_ofs(u, EXT)) bus_rdata = DW'(stat_q[u]);
            if (bus_addr == en_ofs(u, EXT))   bus_rdata = DW'(en_q[u]);
            if (EXT && bus_addr == enclr_ofs(u)) bus_rdata = DW'(en_q[u]);
        end
    end
endmodule

// File: rtl/mbx_checker.sv
`timescale 1ns/1ps
module mbx_checker
    import mbx_pkg::*;
#(
    parameter int NQ    = 4,
    parameter int NU    = 3,
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    parameter int CW    = 3,
    parameter int SW    = 2 * NQ
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [8:0]            bus_addr,
    input logic                  bus_we,
    input logic                  bus_re,
    input logic [DW-1:0]         bus_rdata,
    input logic [NQ-1:0][CW-1:0] q_count,
    input logic [NQ-1:0]         q_full,
    input logic [NU-1:0][SW-1:0] stat_q
);
    for (genvar m = 0; m < NQ; m++) begin : g_q
        AST_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
            q_full[m] |-> q_count[m] == CW'(DEPTH)); // R3
        AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            q_count[m] <= CW'(DEPTH)); // R2
        AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_re && bus_addr == msg_ofs(m) && q_count[m] == '0) |-> bus_rdata == '0); // R4
        AST_DROP_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && !bus_re && bus_addr == msg_ofs(m) && q_count[m] == CW'(DEPTH))
            |=> $stable(q_count[m])); // R4
        for (genvar u = 0; u < NU; u++) begin : g_u
            AST_NEWMSG_SET: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_we && bus_addr == msg_ofs(m) && q_count[m] < CW'(DEPTH))
                |=> stat_q[u][2*m]); // R5
            AST_NOTFULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_re && bus_addr == msg_ofs(m) && q_count[m] == CW'(DEPTH))
                |=> stat_q[u][2*m+1]); // R5
        end
    end
endmodule

bind mbx_top mbx_checker #(
    .NQ(NQ), .NU(NU), .DEPTH(DEPTH), .DW(DW), .CW(CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .q_count   (q_count),
    .q_full    (q_full),
    .stat_q    (stat_q)
);

// File: tb/sim_mbx_top.sv
`timescale 1ns/1ps
module sim_mbx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we0 = 1'b0, re0 = 1'b0, we1 = 1'b0, re1 = 1'b0;
    logic [31:0] rdata0, rdata1;
    logic [2:0]  irq0, irq1;
    bit          sel = 1'b0;
    bit          done = 1'b0;
    int          total = 0;
    int          bad = 0;

    always #2.5 clk = ~clk;

    mbx_top #(.EXT(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we0),
        .bus_wdata(wdata), .bus_re(re0), .bus_rdata(rdata0), .irq_o(irq0)
    );

    mbx_top #(.EXT(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we1),
        .bus_wdata(wdata), .bus_re(re1), .bus_rdata(rdata1), .irq_o(irq1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (sel) we1 = 1'b1; else we0 = 1'b1;
        @(negedge clk);
        we0 = 1'b0; we1 = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        if (sel) re1 = 1'b1; else re0 = 1'b1;
        #1;
        d = sel ? rdata1 : rdata0;
        @(negedge clk);
        re0 = 1'b0; re1 = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        sel = 1'b0;
        rd(9'h100, d); chk("R11 status u0", d, 0);
        rd(9'h104, d); chk("R11 enable u0", d, 0);
        rd(9'h0C0, d); chk("R11 count q0", d, 0);
        rd(9'h080, d); chk("R11 full q0", d, 0);
        chk("R11 irq basic", {29'd0, irq0}, 0);
        chk("R11 irq ext", {29'd0, irq1}, 0);
    endtask

    task automatic t_revision();
        logic [31:0] d;
        sel = 1'b0;
        rd(9'h000, d); chk("R1 revision", d, 32'h21);
        wr(9'h000, 32'hFFFF_FFFF);
        rd(9'h000, d); chk("R1 revision after write", d, 32'h21);
    endtask

    task automatic t_fifo_order();
        logic [31:0] d;
        sel = 1'b0;
        for (int i = 0; i < 4; i++) wr(9'h044, 32'hA000_0000 + i);
        rd(9'h0C4, d); chk("R3 count full", d, 4);
        rd(9'h084, d); chk("R3 full flag", d, 1);
        wr(9'h044, 32'hDEAD_BEEF);
        rd(9'h0C4, d); chk("R4 count after dropped write", d, 4);
        for (int i = 0; i < 4; i++) begin
            rd(9'h044, d); chk("R2 pop order", d, 32'hA000_0000 + i);
            if (i == 0) begin
                logic [31:0] f;
                rd(9'h084, f); chk("R3 not full after pop", f, 0);
            end
        end
        rd(9'h044, d); chk("R4 empty read", d, 0);
        rd(9'h0C4, d); chk("R4 count stays zero", d, 0);
    endtask

    task automatic t_status();
        logic [31:0] d;
        sel = 1'b0;
        rd(9'h100, d); chk("R5 status u0 q1 bits", d, 32'h0C);
        rd(9'h108, d); chk("R5 status u1 q1 bits", d, 32'h0C);
        rd(9'h110, d); chk("R5 status u2 q1 bits", d, 32'h0C);
        wr(9'h100, 32'h04);
        rd(9'h100, d); chk("R6 one clears bit", d, 32'h08);
        wr(9'h100, 32'h00);
        rd(9'h100, d); chk("R6 zero keeps bit", d, 32'h08);
        rd(9'h108, d); chk("R6 other user untouched", d, 32'h0C);
        wr(9'h100, 32'hFF);
        rd(9'h100, d); chk("R6 clear all", d, 0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        sel = 1'b0;
        wr(9'h10C, 32'h01);
        rd(9'h10C, d); chk("R8 enable readback", d, 32'h01);
        chk("R7 no irq while masked", {29'd0, irq0}, 0);
        wr(9'h040, 32'h0000_00AB);
        chk("R7 irq on new message", {29'd0, irq0}, 32'b010);
        wr(9'h108, 32'h01);
        chk("R7 irq drops after clear", {29'd0, irq0}, 0);
        wr(9'h10C, 32'h08);
        chk("R8 rewrite enables pending source", {29'd0, irq0}, 32'b010);
        wr(9'h10C, 32'h00);
        chk("R8 rewrite disables source", {29'd0, irq0}, 0);
        rd(9'h040, d); chk("R2 single word", d, 32'hAB);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        sel = 1'b0;
        wr(9'h01C, 32'hFFFF_FFFF);
        rd(9'h01C, d); chk("R10 unmapped read", d, 0);
        rd(9'h11C, d); chk("R10 unmapped above users", d, 0);
        wr(9'h0F0, 32'h1234_5678);
        rd(9'h0C0, d); chk("R10 write ignored count", d, 0);
        wr(9'h080, 32'h1);
        rd(9'h080, d); chk("R3 full flag not writable", d, 0);
    endtask

    task automatic t_ext();
        logic [31:0] d;
        sel = 1'b1;
        rd(9'h100, d); chk("R10 ext hole", d, 0);
        wr(9'h108, 32'h05);
        rd(9'h108, d); chk("R9 set alias", d, 32'h05);
        rd(9'h10C, d); chk("R9 clear alias reads enable", d, 32'h05);
        wr(9'h108, 32'h02);
        rd(9'h108, d); chk("R9 set ors", d, 32'h07);
        wr(9'h10C, 32'h04);
        rd(9'h108, d); chk("R9 clear alias", d, 32'h03);
        wr(9'h040, 32'h55);
        rd(9'h104, d); chk("R9 ext status", d, 32'h01);
        rd(9'h124, d); chk("R5 ext user2 status", d, 32'h01);
        chk("R7 ext irq", {29'd0, irq1}, 32'b001);
        wr(9'h104, 32'h01);
        chk("R6 ext clear", {29'd0, irq1}, 0);
        sel = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_revision();
        t_fifo_order();
        t_status();
        t_irq();
        t_unmapped();
        t_ext();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule